// File: doc/BRIEF.md
# SMBus Block-Write Register Target

This block is a write-only SMBus/I2C target that fills an internal byte-addressed register space from block-write transactions. Oversampled SCL and SDA come in and pass through a synchronizer. The block detects START and STOP, checks its own 7-bit address, and accepts only the block-write command code. It pulls SDA low through an open-drain enable to acknowledge.

The byte after the command is a count. It is acknowledged and then ignored. The next byte sets the starting register address. Every byte after that goes out on a single-cycle write port (address, data, strobe), and the address then advances by one. The address saturates at 0xFF and does not wrap. Bytes aimed past the implemented space are acknowledged but produce no strobe. The master may send any number of bytes before STOP. The target address and the register space size are parameters.

Top module: `smbw_block_target`

## Requirements
- R1: START (SDA falls while SCL is high) begins address matching, also in the middle of a transaction. An address byte equal to {TARGET_ADDR, 0} (write bit is LSB, 0) is acknowledged. STOP (SDA rises while SCL is high) returns the block to idle.
- R2: An address byte with another address, or with the LSB set to 1, is not acknowledged. All later bytes are also not acknowledged and produce no write, until the next START or STOP.
- R3: After a matched address, command byte 0xF0 is acknowledged. Any other command byte is not acknowledged, and the rest of the transaction is ignored as in R2.
- R4: The byte after the command is acknowledged and has no effect on how many later bytes are accepted. Bytes beyond that count, and beyond 32 in total, are all accepted until STOP.
- R5: The first byte after the count is acknowledged and loaded as the start register address. It produces no write.
- R6: Each later byte is acknowledged and produces exactly one single-cycle wr_en pulse. The pulse carries the current address on wr_addr and the byte on wr_data, and the address then advances by one. A pulse only follows an SCL falling edge.
- R7: The address never wraps. Once it is 0xFF, every later byte writes address 0xFF.
- R8: A byte aimed at an address of REG_COUNT or higher is acknowledged, but wr_en stays low for it.
- R9: An acknowledge drives sda_oe high from the SCL falling edge after the eighth bit until the SCL falling edge after the ninth bit. sda_oe is low at every other time, including after reset, START and STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line (wired-AND bus value) |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| wr_addr | output | 8 | Register address of the current write |
| wr_data | output | 8 | Data byte of the current write |
| wr_en | output | 1 | Single-cycle write strobe |

## Verification
On every cycle, the assertions check four things. The acknowledge enable changes only after an SCL fall, START or STOP, and it is dropped by START and STOP. Every write strobe is a single pulse that lands in the implemented space. Successive writes within a transaction step the address by one, or hold it at 0xFF. The bench scenarios cover what depends on byte content and order. These are address and direction matching, command rejection, the ignored count, the start address byte that is never written, and more than 32 bytes in one transaction. They also cover a repeated START that switches between two targets on one bus, and dropped writes past the register space.

// File: rtl/smbw_pkg.sv
// Shared types for the SMBus block-write target.
// Assumes: one byte-wide register address space of at most 256 entries.
package smbw_pkg;

    // Position of the target inside one bus transaction.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_ADDR,   // receiving the address byte
        ST_CMD,    // receiving the command byte
        ST_COUNT,  // receiving the ignored count byte
        ST_BASE,   // receiving the start register address
        ST_DATA,   // receiving data bytes
        ST_SKIP    // not addressed: stay silent until START or STOP
    } smbw_state_t;

    localparam logic [7:0] SMBW_CMD_BLOCK_WR = 8'hF0;

endpackage

// File: rtl/smbw_bus_events.sv
// Synchronizes SCL and SDA and reports their edges and the bus conditions.
// Assumes: both lines idle high; SYNC_STAGES >= 2.
module smbw_bus_events #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_pipe;
    logic [TOP:0] sda_pipe;
    logic         scl_prev;
    logic         sda_prev;
    logic         scl_s;
    logic         sda_s;

    // Synchronizer chains plus one history flop per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
            scl_prev <= scl_pipe[TOP];
            sda_prev <= sda_pipe[TOP];
        end
    end

    assign scl_s = scl_pipe[TOP];
    assign sda_s = sda_pipe[TOP];

    // Edge and condition decode on the synchronized lines.
    always_comb begin
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        sda_lvl   = sda_s;
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/smbw_addr_ptr.sv
// Register address pointer: loads a start address and advances by one per
// byte, saturating at its maximum. Flags whether it is inside the space.
// Assumes: REG_COUNT <= 2**AW.
module smbw_addr_ptr #(
    parameter int AW        = 8,
    parameter int REG_COUNT = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic          in_range
);
    localparam logic [AW-1:0] PTR_MAX = '1;
    localparam logic [AW:0]   LIMIT   = (AW+1)'(REG_COUNT);

    // Pointer update: load wins, step saturates at PTR_MAX.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step && ptr != PTR_MAX) begin
            ptr <= ptr + AW'(1);
        end
    end

    // Range flag for the current pointer.
    always_comb begin
        in_range = ({1'b0, ptr} < LIMIT);
    end

endmodule

// File: rtl/smbw_block_target.sv
// SMBus target accepting block writes into a byte-addressed register space.
// Bytes are shifted in on SCL rise; at the SCL fall after bit 8 the byte is
// judged, the acknowledge is driven for the ninth clock and writes issue.
// Assumes: SCL/SDA oversampled by clk; no clock stretching, no reads.
module smbw_block_target
    import smbw_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h2C,
    parameter int         REG_COUNT   = 48,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       wr_en
);
    localparam int              BYTE_W   = 8;
    localparam int              CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [7:0]      ADDR_WR  = {TARGET_ADDR, 1'b0};

    logic              scl_rise, scl_fall, sda_lvl, start_det, stop_det;
    smbw_state_t       state, state_nxt;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              in_ack;
    logic              byte_done;
    logic              ack_now;
    logic              ptr_load, ptr_step, wr_fire;
    logic [7:0]        ptr;
    logic              in_range;

    smbw_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smbw_addr_ptr #(.AW(8), .REG_COUNT(REG_COUNT)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (shreg),
        .step     (ptr_step),
        .ptr      (ptr),
        .in_range (in_range)
    );

    assign byte_done = scl_fall && (bit_cnt == ACK_SLOT) && !in_ack;

    // Judge a completed byte: acknowledge, next state, pointer and write.
    always_comb begin
        ack_now   = 1'b0;
        state_nxt = state;
        ptr_load  = 1'b0;
        ptr_step  = 1'b0;
        wr_fire   = 1'b0;
        if (byte_done) begin
            case (state)
                ST_ADDR: begin
                    ack_now   = (shreg == ADDR_WR);
                    state_nxt = ack_now ? ST_CMD : ST_SKIP;
                end
                ST_CMD: begin
                    ack_now   = (shreg == SMBW_CMD_BLOCK_WR);
                    state_nxt = ack_now ? ST_COUNT : ST_SKIP;
                end
                ST_COUNT: begin
                    ack_now   = 1'b1;
                    state_nxt = ST_BASE;
                end
                ST_BASE: begin
                    ack_now   = 1'b1;
                    ptr_load  = 1'b1;
                    state_nxt = ST_DATA;
                end
                ST_DATA: begin
                    ack_now  = 1'b1;
                    ptr_step = 1'b1;
                    wr_fire  = in_range;
                end
                default: begin
                    ack_now = 1'b0;
                end
            endcase
        end
    end

    // Transaction state, bit shifting, acknowledge drive and write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else if (start_det || stop_det) begin
            state   <= start_det ? ST_ADDR : ST_IDLE;
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
        end else begin
            wr_en <= wr_fire;
            if (wr_fire) begin
                wr_addr <= ptr;
                wr_data <= shreg;
            end
            if (scl_rise && bit_cnt < ACK_SLOT && !in_ack) begin
                shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
            if (byte_done) begin
                in_ack <= 1'b1;
                sda_oe <= ack_now;
                state  <= state_nxt;
            end else if (scl_fall && in_ack) begin
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/smbw_block_target_chk.sv
// Protocol checker for smbw_block_target, attached by bind below.
// Assumes: the internal event nets of the target are visible at its scope.
module smbw_block_target_chk #(
    parameter int REG_COUNT = 48
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det
);
    localparam logic [8:0] LIMIT = 9'(REG_COUNT);

    logic       seen;
    logic [7:0] last_addr;
    logic [7:0] next_addr;

    // Remember the last written address within the current transaction.
    always_ff @(posedge clk) begin
        if (!rst_n || start_det) begin
            seen      <= 1'b0;
            last_addr <= '0;
        end else if (wr_en) begin
            seen      <= 1'b1;
            last_addr <= wr_addr;
        end
    end

    assign next_addr = (last_addr == 8'hFF) ? 8'hFF : last_addr + 8'd1;

    // R9
    oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    // R9
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !sda_oe);

    // R8
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_addr} < LIMIT));

    // R6
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R6
    wr_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(scl_fall));

    // R7
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seen) |-> (wr_addr == next_addr));

endmodule

bind smbw_block_target smbw_block_target_chk #(.REG_COUNT(REG_COUNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/test_smbw_block_target.sv
// Bench: two targets share one bus (small space and full space). A
// behavioural model predicts acknowledges and writes; writes are compared
// on every clock against per-target expectation queues.
module test_smbw_block_target;

    localparam int         Q      = 6;
    localparam logic [6:0] ADDR_A = 7'h2C;
    localparam logic [6:0] ADDR_B = 7'h3A;
    localparam int         SIZE_A = 48;
    localparam int         SIZE_B = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       oe_a, oe_b, wr_a, wr_b;
    logic [7:0] wa_a, wd_a, wa_b, wd_b;
    logic       bus_sda;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_a[$];
    logic [15:0] exp_b[$];

    int m_phase = -1;  // -1 idle, 0 addr, 1 cmd, 2 count, 3 base, 4 data, 5 skip
    int m_tgt   = -1;
    int m_ptr   = 0;

    always #5 clk = ~clk;

    assign bus_sda = m_sda & ~oe_a & ~oe_b;

    smbw_block_target #(.TARGET_ADDR(ADDR_A), .REG_COUNT(SIZE_A)) i_smbw_block_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus_sda),
        .sda_oe(oe_a), .wr_addr(wa_a), .wr_data(wd_a), .wr_en(wr_a));

    smbw_block_target #(.TARGET_ADDR(ADDR_B), .REG_COUNT(SIZE_B)) i_full (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus_sda),
        .sda_oe(oe_b), .wr_addr(wa_b), .wr_data(wd_b), .wr_en(wr_b));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Per-clock comparison of write strobes against the model's queues (R6 R8).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (wr_a) begin
                if (exp_a.size() == 0) chk(1'b0, "R8", "unexpected write A", int'({wa_a, wd_a}), 0);
                else begin
                    logic [15:0] e;
                    e = exp_a.pop_front();
                    chk({wa_a, wd_a} == e, "R6", "write A", int'({wa_a, wd_a}), int'(e));
                end
            end
            if (wr_b) begin
                if (exp_b.size() == 0) chk(1'b0, "R8", "unexpected write B", int'({wa_b, wd_b}), 0);
                else begin
                    logic [15:0] e;
                    e = exp_b.pop_front();
                    chk({wa_b, wd_b} == e, "R7", "write B", int'({wa_b, wd_b}), int'(e));
                end
            end
        end
    end

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        scl = 1'b1;   wq(2*Q);
        m_sda = 1'b0; wq(2*Q);
        scl = 1'b0;   wq(Q);
        m_phase = 0;
        m_tgt   = -1;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        scl = 1'b1;   wq(2*Q);
        m_sda = 1'b1; wq(2*Q);
        m_phase = -1;
        chk(exp_a.size() == 0 && exp_b.size() == 0, "R6", "writes pending at STOP",
            exp_a.size() + exp_b.size(), 0);
        chk(!oe_a && !oe_b, "R9", "sda_oe after STOP", int'({oe_a, oe_b}), 0);
    endtask

    // Sends one byte, predicts and checks the acknowledge.
    task automatic send_byte(input logic [7:0] b);
        bit    exp_ack = 1'b0;
        string req = "R2";
        case (m_phase)
            0: begin
                req = "R1";
                if (b == {ADDR_A, 1'b0}) begin m_tgt = 0; exp_ack = 1'b1; m_phase = 1; end
                else if (b == {ADDR_B, 1'b0}) begin m_tgt = 1; exp_ack = 1'b1; m_phase = 1; end
                else begin req = "R2"; m_phase = 5; end
            end
            1: begin
                req = "R3";
                exp_ack = (b == 8'hF0);
                m_phase = exp_ack ? 2 : 5;
            end
            2: begin req = "R4"; exp_ack = 1'b1; m_phase = 3; end
            3: begin req = "R5"; exp_ack = 1'b1; m_ptr = int'(b); m_phase = 4; end
            4: begin
                req = "R8";
                exp_ack = 1'b1;
                if (m_ptr < ((m_tgt == 1) ? SIZE_B : SIZE_A)) begin
                    if (m_tgt == 1) exp_b.push_back({8'(m_ptr), b});
                    else exp_a.push_back({8'(m_ptr), b});
                end
                if (m_ptr != 255) m_ptr++;
            end
            default: begin req = "R2"; exp_ack = 1'b0; end
        endcase
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q);
            scl = 1'b1;
            if (i == 7) chk(!oe_a && !oe_b, "R9", "sda_oe during data bit", int'({oe_a, oe_b}), 0);
            wq(2*Q);
            scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        chk(!bus_sda == exp_ack, req, "acknowledge", int'(!bus_sda), int'(exp_ack));
        wq(Q);
        scl = 1'b0;   wq(Q);
        chk(!oe_a && !oe_b, "R9", "sda_oe released after ack", int'({oe_a, oe_b}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(4);
        // Reset state (R9)
        chk(!oe_a && !oe_b && !wr_a && !wr_b, "R9", "reset outputs",
            int'({oe_a, oe_b, wr_a, wr_b}), 0);

        // R1 R5 R6: normal block write to A
        bus_start();
        send_byte({ADDR_A, 1'b0}); send_byte(8'hF0); send_byte(8'd3); send_byte(8'h10);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        bus_stop();

        // R4: more bytes than the count, to B
        bus_start();
        send_byte({ADDR_B, 1'b0}); send_byte(8'hF0); send_byte(8'd1); send_byte(8'h05);
        for (int i = 0; i < 4; i++) send_byte(8'hA0 + 8'(i));
        bus_stop();

        // R4: fewer bytes than the count
        bus_start();
        send_byte({ADDR_A, 1'b0}); send_byte(8'hF0); send_byte(8'd5); send_byte(8'h20);
        send_byte(8'h5A);
        bus_stop();

        // R7: saturation at 0xFF on the full-space target
        bus_start();
        send_byte({ADDR_B, 1'b0}); send_byte(8'hF0); send_byte(8'd4); send_byte(8'hFD);
        for (int i = 0; i < 5; i++) send_byte(8'hC0 + 8'(i));
        bus_stop();

        // R8: writes past the implemented space are acknowledged, dropped
        bus_start();
        send_byte({ADDR_A, 1'b0}); send_byte(8'hF0); send_byte(8'd4); send_byte(8'h2E);
        for (int i = 0; i < 4; i++) send_byte(8'h70 + 8'(i));
        bus_stop();

        // R2: wrong address, then read direction
        bus_start();
        send_byte(8'h5A); send_byte(8'hF0); send_byte(8'd1); send_byte(8'h00); send_byte(8'h99);
        bus_stop();
        bus_start();
        send_byte({ADDR_A, 1'b1}); send_byte(8'hF0); send_byte(8'h00); send_byte(8'h44);
        bus_stop();

        // R3: wrong command
        bus_start();
        send_byte({ADDR_A, 1'b0}); send_byte(8'hF1); send_byte(8'd2); send_byte(8'h10);
        send_byte(8'h55);
        bus_stop();

        // R1: repeated START switches target mid-transaction
        bus_start();
        send_byte({ADDR_A, 1'b0}); send_byte(8'hF0); send_byte(8'd2); send_byte(8'h08);
        send_byte(8'h77);
        bus_start();
        send_byte({ADDR_B, 1'b0}); send_byte(8'hF0); send_byte(8'd1); send_byte(8'h40);
        send_byte(8'h99);
        bus_stop();

        // R4 R6: 40 data bytes, beyond the 32-byte limit
        bus_start();
        send_byte({ADDR_A, 1'b0}); send_byte(8'hF0); send_byte(8'd32); send_byte(8'h00);
        for (int i = 0; i < 40; i++) send_byte(8'(i * 3 + 1));
        bus_stop();

        wq(10);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule